// File: doc/BRIEF.md
# L1 Data Cache Stride Prefetcher

This block sits beside the path between a processor core and its L1 data cache. It snoops each request the core sends (valid, virtual address, command code and log2 access size) and later learns whether that access missed. Missing loads and stores train a small stride table. When a stream shows the same non-zero stride twice in a row, the block requests the 64-byte line that holds the next address in that stream. The request goes out on a registered ready/valid port together with a write-intent bit.

The cache port gives this block the lowest priority, so it must limit itself. Only one prefetch is outstanding at a time. A rejection (nack) arrives two cycles after the handshake it refers to. The first nack for a prefetch causes one retry. A second nack drops it and lengthens a minimum gap between issues. Each accepted prefetch halves that gap. A line that matches either of the last two issued lines is not requested again.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `pfValid` and `pfWrite` are low.
- R2: Only accesses with command 0 (load) or 1 (store) whose miss flag is high two cycles after the access train the table. Other commands and hits leave the table unchanged.
- R3: The table has 4 direct-mapped entries. An entry is chosen by address bits [13:12] and tagged by the bits above them. When a miss in a matching entry gives a non-zero stride equal to the stride stored in that entry, the block computes the target (miss address + stride) rounded down to a 64-byte line. That target appears on `pfAddr` with `pfValid` high in the cycle after the miss flag is sampled. A miss on a new tag restarts the entry with stride zero.
- R4: Before training, each snooped address is rounded down to a multiple of 2^size bytes.
- R5: `pfWrite` is 1 when the training access was a store and 0 when it was a load.
- R6: A request is taken only on a cycle with `pfValid` and `pfReady` both high. While `pfReady` is low, `pfValid`, `pfAddr` and `pfWrite` hold. The outputs come straight from registers.
- R7: Every address driven on `pfAddr` has its low three bits at zero.
- R8: A target line equal to either of the last two issued lines (retries not counted) is not requested.
- R9: A nack two cycles after the first handshake of a prefetch re-presents the same address in the next cycle.
- R10: A nack on the retried prefetch drops it. It raises the gap by 16 cycles, saturating at the counter maximum. An accepted prefetch halves the gap. After each resolution, new targets are discarded until that many cycles have passed.
- R11: While a prefetch is pending or inside its two-cycle nack window, new targets are discarded, and the held request is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoopValid | input | 1 | Core presents a cache request this cycle |
| snoopAddr | input | ADDR_W | Virtual address of the snooped request |
| snoopCmd | input | CMD_W | Command code, 0 load, 1 store |
| snoopSize | input | 2 | Log2 of the access size in bytes |
| snoopMiss | input | 1 | Miss flag for the access presented two cycles earlier |
| pfReady | input | 1 | Cache can take a prefetch this cycle |
| pfNack | input | 1 | Prefetch handed over two cycles earlier was rejected |
| pfValid | output | 1 | Prefetch request valid |
| pfAddr | output | ADDR_W | Line-aligned prefetch address |
| pfWrite | output | 1 | Prefetch is made with intent to write |

## Verification
The bench builds the block with a 32-bit address, the default 4-entry table and 64-byte lines, and a 6-bit gap counter. With this setup every table index and tag change can be reached by moving the stream to a new 4 KiB page. The bench sweeps positive and negative strides from 8 to 512 bytes, with loads and stores alternating, and computes each target line arithmetically. The short gap counter keeps the throttle windows after a drop and after an acceptance to a few tens of cycles, so both the discarding of targets and the recovery after the window are observed directly.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef struct packed {
    logic issueNew;
    logic issueRetry;
  } pfStrobe_t;
endpackage

// File: rtl/stride_pf_datapath.sv
module stride_pf_datapath
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CMD_W      = 5,
  parameter int ENTRIES    = 4,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BITS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [CMD_W-1:0]  snoopCmd,
  input  logic [1:0]        snoopSize,
  input  logic              snoopMiss,
  input  logic              pfReady,
  input  pfStrobe_t         strobe,
  output logic              candValid,
  output logic              candDup,
  output logic              pfBusy,
  output logic              f2Valid,
  output logic              f2Retried,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  output logic              pfWrite
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LINE_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - PAGE_BITS - IDX_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_W) - ADDR_W'(1));

  // snoop pipeline, two stages to line up with the late miss flag
  logic              s1Valid, s2Valid, s1Ok, s2Ok, s1Write, s2Write;
  logic [ADDR_W-1:0] s1Addr, s2Addr, normAddr;

  assign normAddr = snoopAddr & ~((ADDR_W'(1) << snoopSize) - ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= snoopValid;
      s2Valid <= s1Valid;
    end
    s1Addr  <= normAddr;
    s1Ok    <= (snoopCmd == CMD_W'(0)) || (snoopCmd == CMD_W'(1));
    s1Write <= (snoopCmd == CMD_W'(1));
    s2Addr  <= s1Addr;
    s2Ok    <= s1Ok;
    s2Write <= s1Write;
  end

  // stride table
  logic              trainEn;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              entValid  [ENTRIES];
  logic [TAG_W-1:0]  entTag    [ENTRIES];
  logic [ADDR_W-1:0] entLast   [ENTRIES];
  logic [ADDR_W-1:0] entStride [ENTRIES];
  logic              tagHit;
  logic [ADDR_W-1:0] newStride, candLine;

  assign trainEn   = s2Valid && s2Ok && snoopMiss;
  assign idx       = s2Addr[PAGE_BITS +: IDX_W];
  assign tag       = s2Addr[ADDR_W-1 -: TAG_W];
  assign tagHit    = entValid[idx] && (entTag[idx] == tag);
  assign newStride = s2Addr - entLast[idx];
  assign candLine  = (s2Addr + newStride) & LINE_MASK;
  assign candValid = trainEn && tagHit && (newStride != '0) && (newStride == entStride[idx]);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entValid[e] <= 1'b0;
      end else if (trainEn && (idx == IDX_W'(e))) begin
        entValid[e]  <= 1'b1;
        entTag[e]    <= tag;
        entLast[e]   <= s2Addr;
        entStride[e] <= tagHit ? newStride : '0;
      end
    end
  end

  // output register, handshake history and recent-line filter
  logic              pfRetried, fire;
  logic              f1Valid, f1Retried, f1Write, f2Write;
  logic [ADDR_W-1:0] f1Addr, f2Addr;
  logic [1:0]        recentValid;
  logic [ADDR_W-1:0] recentLine [2];

  assign fire    = pfValid && pfReady;
  assign pfBusy  = pfValid || f1Valid || f2Valid;
  assign candDup = (recentValid[0] && (recentLine[0] == candLine)) ||
                   (recentValid[1] && (recentLine[1] == candLine));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfValid     <= 1'b0;
      pfWrite     <= 1'b0;
      pfRetried   <= 1'b0;
      pfAddr      <= '0;
      f1Valid     <= 1'b0;
      f2Valid     <= 1'b0;
      recentValid <= '0;
    end else begin
      if (strobe.issueRetry) begin
        pfValid   <= 1'b1;
        pfAddr    <= f2Addr;
        pfWrite   <= f2Write;
        pfRetried <= 1'b1;
      end else if (strobe.issueNew) begin
        pfValid   <= 1'b1;
        pfAddr    <= candLine;
        pfWrite   <= s2Write;
        pfRetried <= 1'b0;
      end else if (fire) begin
        pfValid <= 1'b0;
      end
      f1Valid <= fire;
      f2Valid <= f1Valid;
      if (fire && !pfRetried) begin
        recentValid   <= {recentValid[0], 1'b1};
        recentLine[1] <= recentLine[0];
        recentLine[0] <= pfAddr;
      end
    end
    f1Addr    <= pfAddr;
    f1Write   <= pfWrite;
    f1Retried <= pfRetried;
    f2Addr    <= f1Addr;
    f2Write   <= f1Write;
    f2Retried <= f1Retried;
  end
endmodule

// File: rtl/stride_pf_ctrl.sv
module stride_pf_ctrl
  import stride_pf_pkg::*;
#(
  parameter int GAP_W    = 8,
  parameter int GAP_STEP = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      candValid,
  input  logic      candDup,
  input  logic      pfBusy,
  input  logic      f2Valid,
  input  logic      f2Retried,
  input  logic      pfNack,
  output pfStrobe_t strobe
);
  localparam logic [GAP_W:0] GAP_MAX = {1'b0, {GAP_W{1'b1}}};

  logic [GAP_W-1:0] gap, cooldown, gapUp;
  logic [GAP_W:0]   gapSum;
  logic             okNow, dropNow;

  assign gapSum  = {1'b0, gap} + (GAP_W+1)'(GAP_STEP);
  assign gapUp   = (gapSum > GAP_MAX) ? GAP_MAX[GAP_W-1:0] : gapSum[GAP_W-1:0];
  assign okNow   = f2Valid && !pfNack;
  assign dropNow = f2Valid && pfNack && f2Retried;

  always_comb begin
    strobe.issueRetry = f2Valid && pfNack && !f2Retried;
    strobe.issueNew   = candValid && !candDup && !pfBusy && (cooldown == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      cooldown <= '0;
    end else if (okNow) begin
      gap      <= gap >> 1;
      cooldown <= gap >> 1;
    end else if (dropNow) begin
      gap      <= gapUp;
      cooldown <= gapUp;
    end else if (cooldown != '0) begin
      cooldown <= cooldown - 1'b1;
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CMD_W      = 5,
  parameter int ENTRIES    = 4,
  parameter int LINE_BYTES = 64,
  parameter int GAP_W      = 8,
  parameter int GAP_STEP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [CMD_W-1:0]  snoopCmd,
  input  logic [1:0]        snoopSize,
  input  logic              snoopMiss,
  input  logic              pfReady,
  input  logic              pfNack,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  output logic              pfWrite
);
  pfStrobe_t strobe;
  logic candValid, candDup, pfBusy, f2Valid, f2Retried;

  stride_pf_datapath #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .ENTRIES(ENTRIES),
    .LINE_BYTES(LINE_BYTES), .PAGE_BITS(12)
  ) i_datapath (
    .clk(clk), .rst_n(rst_n), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .snoopCmd(snoopCmd), .snoopSize(snoopSize), .snoopMiss(snoopMiss),
    .pfReady(pfReady), .strobe(strobe), .candValid(candValid), .candDup(candDup),
    .pfBusy(pfBusy), .f2Valid(f2Valid), .f2Retried(f2Retried),
    .pfValid(pfValid), .pfAddr(pfAddr), .pfWrite(pfWrite)
  );

  stride_pf_ctrl #(.GAP_W(GAP_W), .GAP_STEP(GAP_STEP)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .candValid(candValid), .candDup(candDup),
    .pfBusy(pfBusy), .f2Valid(f2Valid), .f2Retried(f2Retried),
    .pfNack(pfNack), .strobe(strobe)
  );
endmodule

// File: rtl/stride_pf_checker.sv
module stride_pf_checker #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoopMiss,
  input logic              pfReady,
  input logic              pfNack,
  input logic              pfValid,
  input logic [ADDR_W-1:0] pfAddr,
  input logic              pfWrite
);
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pfValid |-> (pfAddr[2:0] == 3'b000));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfAddr) && $stable(pfWrite)));

  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pfValid && pfReady) |=> !pfValid);

  // R3 / R9: a request only appears after a trained miss or a nack
  assert_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfValid) |-> ($past(snoopMiss) || $past(pfNack)));
endmodule

bind stride_prefetcher stride_pf_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rst_n(rst_n), .snoopMiss(snoopMiss), .pfReady(pfReady),
  .pfNack(pfNack), .pfValid(pfValid), .pfAddr(pfAddr), .pfWrite(pfWrite)
);

// File: tb/test_stride_prefetcher.sv
`timescale 1ns/1ps
module test_stride_prefetcher;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;
  logic [4:0]    snoopCmd = '0;
  logic [1:0]    snoopSize = '0;
  logic          snoopMiss = 1'b0;
  logic          pfReady = 1'b1;
  logic          pfNack = 1'b0;
  logic          pfValid;
  logic [AW-1:0] pfAddr;
  logic          pfWrite;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;
  int page = 1;

  always #2.5 clk = ~clk;

  stride_prefetcher #(.ADDR_W(AW), .CMD_W(5), .ENTRIES(4), .LINE_BYTES(64),
                      .GAP_W(6), .GAP_STEP(16)) i_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .snoopCmd(snoopCmd), .snoopSize(snoopSize), .snoopMiss(snoopMiss),
    .pfReady(pfReady), .pfNack(pfNack), .pfValid(pfValid), .pfAddr(pfAddr),
    .pfWrite(pfWrite)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finishRun();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // present one access, then its miss flag two cycles later; returns at the
  // negedge after the edge that samples the miss flag
  task automatic access(input logic [AW-1:0] a, input int cmd, input int sz, input bit miss);
    @(negedge clk);
    snoopValid = 1'b1; snoopAddr = a; snoopCmd = 5'(cmd); snoopSize = 2'(sz);
    @(posedge clk); @(negedge clk);
    snoopValid = 1'b0;
    @(posedge clk); @(negedge clk);
    snoopMiss = miss;
    @(posedge clk); @(negedge clk);
    snoopMiss = 1'b0;
  endtask

  function automatic logic [AW-1:0] pageBase();
    pageBase = AW'(page) << 12;
  endfunction

  initial begin
    logic [AW-1:0] b, exp;
    int strides [11] = '{8, 16, 24, 64, 128, 192, 512, -8, -64, -128, -512};

    // R1 reset state
    idle(3);
    check(!pfValid && !pfWrite, "R1 during reset", {pfValid, pfWrite}, 0);
    rst_n = 1'b1;
    idle(1);
    check(!pfValid && !pfWrite, "R1 after reset", {pfValid, pfWrite}, 0);

    // R3 R5 R7 stride sweep, alternating load and store
    for (int i = 0; i < 11; i++) begin
      page++;
      b = pageBase() + AW'(2048);
      access(b, i % 2, 3, 1'b1);
      access(b + AW'(strides[i]), i % 2, 3, 1'b1);
      check(!pfValid, "R3 one stride only", pfValid, 0);
      access(b + AW'(2 * strides[i]), i % 2, 3, 1'b1);
      exp = (b + AW'(3 * strides[i])) & ~AW'(63);
      check(pfValid && pfAddr == exp, "R3 target line", pfAddr, exp);
      check(pfWrite == (i % 2), "R5 write intent", pfWrite, i % 2);
      check(pfAddr[2:0] == 0, "R7 alignment", pfAddr[2:0], 0);
      idle(5);
    end

    // R4 size rounding: 0x003/2, 0x047/3, 0x081/1 -> 0x000, 0x040, 0x080
    page++;
    b = pageBase();
    access(b + AW'(3), 0, 2, 1'b1);
    access(b + AW'(71), 0, 3, 1'b1);
    access(b + AW'(129), 0, 1, 1'b1);
    exp = b + AW'(192);
    check(pfValid && pfAddr == exp, "R4 size rounding", pfAddr, exp);
    idle(5);

    // R2 ignored command and hit in the middle of a stream
    page++;
    b = pageBase();
    access(b, 0, 3, 1'b1);
    access(b + AW'(64), 0, 3, 1'b1);
    access(b + AW'(1000), 2, 3, 1'b1);
    check(!pfValid, "R2 other command", pfValid, 0);
    access(b + AW'(2000), 0, 3, 1'b0);
    check(!pfValid, "R2 hit", pfValid, 0);
    access(b + AW'(128), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(192), "R2 stream kept", pfAddr, b + AW'(192));
    idle(5);

    // R8 recent-line filter with an 8-byte stride
    page++;
    b = pageBase();
    access(b, 0, 3, 1'b1);
    access(b + AW'(8), 0, 3, 1'b1);
    access(b + AW'(16), 0, 3, 1'b1);
    check(pfValid && pfAddr == b, "R8 first line", pfAddr, b);
    idle(5);
    for (int k = 3; k < 7; k++) begin
      access(b + AW'(8 * k), 0, 3, 1'b1);
      check(!pfValid, "R8 repeated line dropped", pfValid, 0);
      idle(5);
    end
    access(b + AW'(56), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(64), "R8 new line", pfAddr, b + AW'(64));
    idle(5);

    // R6 R11 hold under back-pressure, new target discarded
    page++;
    b = pageBase();
    pfReady = 1'b0;
    access(b, 0, 3, 1'b1);
    access(b + AW'(64), 0, 3, 1'b1);
    access(b + AW'(128), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(192), "R6 issued", pfAddr, b + AW'(192));
    access(b + AW'(192), 1, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(192) && !pfWrite, "R11 held request", pfAddr, b + AW'(192));
    pfReady = 1'b1;
    idle(1);
    check(!pfValid, "R6 taken on handshake", pfValid, 0);
    idle(4);
    check(!pfValid, "R11 discarded target", pfValid, 0);

    // R9 retry, R10 drop and throttle
    page++;
    b = pageBase();
    access(b, 0, 3, 1'b1);
    access(b + AW'(64), 0, 3, 1'b1);
    access(b + AW'(128), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(192), "R9 first issue", pfAddr, b + AW'(192));
    @(posedge clk); @(negedge clk);
    check(!pfValid, "R9 handshake", pfValid, 0);
    @(posedge clk); @(negedge clk);
    pfNack = 1'b1;
    @(posedge clk); @(negedge clk);
    pfNack = 1'b0;
    check(pfValid && pfAddr == b + AW'(192), "R9 retry", pfAddr, b + AW'(192));
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    pfNack = 1'b1;
    @(posedge clk); @(negedge clk);
    pfNack = 1'b0;
    check(!pfValid, "R10 second nack drops", pfValid, 0);
    access(b + AW'(192), 0, 3, 1'b1);
    check(!pfValid, "R10 gap after drop", pfValid, 0);
    idle(25);
    access(b + AW'(256), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(320), "R10 gap expired", pfAddr, b + AW'(320));
    access(b + AW'(320), 0, 3, 1'b1);
    check(!pfValid, "R10 busy at resolve", pfValid, 0);
    access(b + AW'(384), 0, 3, 1'b1);
    check(!pfValid, "R10 halved gap throttles", pfValid, 0);
    idle(12);
    access(b + AW'(448), 0, 3, 1'b1);
    check(pfValid && pfAddr == b + AW'(512), "R10 after halved gap", pfAddr, b + AW'(512));
    idle(5);

    finishRun();
  end
endmodule